// File: doc/BRIEF.md
# Cascaded Swallow-Cell Programmable Clock Divider

This block divides a fast clock by an integer ratio from 16 to 31 for the feedback path of a fractional-N synthesizer. It is a chain of four divide-by-2/3 cells. Each cell normally completes a cycle in two ticks of its enable. Once per output period it may stretch that cycle to three ticks and so absorb one extra tick. Cell 0 advances on every input clock. Each later cell advances only on the tick in which the cell below it wraps.

A cell stretches only when its bit of the modulus word is set and every cell above it is in its final phase. That combination occurs exactly once per output period for each cell. Bit i therefore adds 2^i input clocks, and the ratio is 16 + word. The modulus word is captured once per output period, on the clock in which the whole chain wraps. A word that changes mid-period therefore only affects the next period.

The divided output is a one-cycle pulse in the input clock domain. Every cell's phase level is also brought out for observation.

Top module: `swallow_divider`

## Requirements
- R1: With a steady modulus word W (unsigned, 4 bits), rising pulses on div_o are spaced exactly 16 + W input clocks apart, for every W from 0 to 15.
- R2: mod_i is sampled only on the clock edge at which div_o goes high. Changes between such edges do not alter the period in progress; the next period uses the value present at that edge.
- R3: div_o is high for exactly one input clock per output period.
- R4: While rst_ni is low, div_o and all bits of stage_o are 0.
- R5: The first div_o pulse after reset release comes on the (16 + W)-th rising clock edge, where W is mod_i at the first edge after release.
- R6: In the cycle div_o is high, every stage_o bit is 0, because all cells restart their cycle together.
- R7: stage_o[0] stays high for 1 clock in a plain cycle and 2 clocks in a stretched cycle. Per output period, the number of 2-clock high runs equals bit 0 of that period's word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_i | input | STAGES | Modulus word; ratio = 2^STAGES + mod_i |
| div_o | output | 1 | One-cycle pulse per divided period |
| stage_o | output | STAGES | Phase level of each cell (high during the non-initial phases) |

## Verification
Every one of the sixteen words is held for two full periods. This separates a wrong weight on any single bit from an off-by-one in the wrap logic. A second pattern rewrites mod_i every few clocks at points that drift across the period. This tells correct once-per-period capture apart from designs that mix the old and new words. A reset in the middle of a run, with a new word, checks that the first period is already the programmed length. The stage-0 run lengths check that the lowest cell stretches at most once, and only when its bit is set.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;
  // phase of one divide-by-2/3 cell; PH_EXTRA only occurs in a stretched cycle
  typedef enum logic [1:0] {
    PH_LOW   = 2'd0,
    PH_HIGH  = 2'd1,
    PH_EXTRA = 2'd2
  } phase_e;
endpackage

// File: rtl/swallow_div_cell.sv
module swallow_div_cell
  import swallow_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stretch_i,
  output logic last_o,
  output logic wrap_o,
  output logic level_o
);
  phase_e ph_q;

  assign last_o  = (ph_q == PH_EXTRA) || ((ph_q == PH_HIGH) && !stretch_i);
  assign wrap_o  = en_i && last_o;
  assign level_o = (ph_q != PH_LOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_LOW;
    end else if (en_i) begin
      unique case (ph_q)
        PH_LOW:  ph_q <= PH_HIGH;
        PH_HIGH: ph_q <= stretch_i ? PH_EXTRA : PH_LOW;
        default: ph_q <= PH_LOW;
      endcase
    end
  end
endmodule

// File: rtl/swallow_div_word.sv
module swallow_div_word #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] eff_o,
  output logic [WIDTH-1:0] hold_o
);
  logic             init_q;
  logic [WIDTH-1:0] hold_q;

  // first edge after reset uses the live word so the opening period is programmed
  assign eff_o  = init_q ? word_i : hold_q;
  assign hold_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b1;
      hold_q <= '0;
    end else begin
      init_q <= 1'b0;
      if (load_i || init_q) hold_q <= word_i;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int unsigned STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAGES-1:0] mod_i,
  output logic              div_o,
  output logic [STAGES-1:0] stage_o
);
  logic [STAGES-1:0] en, wrap, last, qual, level;
  logic [STAGES-1:0] word_eff, word_q;
  logic              div_q;
  logic              wrap_all;

  assign en[0]    = 1'b1;
  assign wrap_all = wrap[STAGES-1];

  swallow_div_word #(.WIDTH(STAGES)) u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap_all),
    .word_i (mod_i),
    .eff_o  (word_eff),
    .hold_o (word_q)
  );

  for (genvar i = 0; i < STAGES; i++) begin : g_cell
    if (i == STAGES - 1) begin : g_top
      assign qual[i] = 1'b1;
    end else begin : g_mid
      // stretch allowed only while every higher cell sits in its final phase
      assign qual[i] = qual[i+1] & last[i+1];
    end
    if (i > 0) begin : g_en
      assign en[i] = wrap[i-1];
    end
    swallow_div_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[i]),
      .stretch_i (word_eff[i] & qual[i]),
      .last_o    (last[i]),
      .wrap_o    (wrap[i]),
      .level_o   (level[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= wrap_all;
  end

  assign div_o   = div_q;
  assign stage_o = level;
endmodule

// File: rtl/swallow_divider_chk.sv
module swallow_divider_chk #(
  parameter int unsigned STAGES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_o,
  input logic [STAGES-1:0] stage_o,
  input logic [STAGES-1:0] word_q
);
  localparam int unsigned GW   = STAGES + 2;
  localparam int unsigned NMIN = 1 << STAGES;
  localparam int unsigned NMAX = (1 << (STAGES + 1)) - 1;

  logic [GW-1:0] gap_q;
  logic          started_q;
  logic [1:0]    age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      started_q <= 1'b0;
      age_q     <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      if (div_o) begin
        gap_q     <= '0;
        started_q <= 1'b1;
      end else if (gap_q != {GW{1'b1}}) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_o && started_q) |-> (gap_q >= GW'(NMIN - 1)) && (gap_q <= GW'(NMAX - 1)));

  // R1
  no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GW'(NMAX));

  // R2
  word_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && word_q != $past(word_q)) |-> div_o);

  // R3
  pulse_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  // R6
  aligned_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |-> (stage_o == '0));

  // R7
  low_cell_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && $past(stage_o[0]) && stage_o[0]) |=> !stage_o[0]);
endmodule

bind swallow_divider swallow_divider_chk #(.STAGES(STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .div_o   (div_o),
  .stage_o (stage_o),
  .word_q  (word_q)
);

// File: tb/swallow_divider_test.sv
module swallow_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES     = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [STAGES-1:0] mod_i = '0;
  logic              div_o;
  logic [STAGES-1:0] stage_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // reference model state
  bit    started;
  int    cnt;
  int    n_cur;
  int    per_word;
  bit    exp_pulse;
  int    run_len;
  int    stretch_cnt;
  string tag = "R1";

  swallow_divider #(.STAGES(STAGES)) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mod_i  (mod_i),
    .div_o  (div_o),
    .stage_o(stage_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_reset();
    started = 0; cnt = 0; n_cur = 0; exp_pulse = 0;
    run_len = 0; stretch_cnt = 0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    cycles++;
    if (!started) begin
      n_cur   = 16 + int'(mod_i);
      started = 1;
    end
    cnt++;
    exp_pulse = (cnt == n_cur);
    if (exp_pulse) begin
      per_word = n_cur - 16;
      cnt      = 0;
      n_cur    = 16 + int'(mod_i);
    end
    @(negedge clk_i);
    check(tag, int'(div_o), int'(exp_pulse));
    // R7: stage 0 high-run lengths
    if (stage_o[0]) begin
      run_len++;
    end else begin
      if (run_len == 2) stretch_cnt++;
      if (run_len > 2) check("R7", run_len, 2);
      run_len = 0;
    end
    if (exp_pulse) begin
      check("R6", int'(stage_o), 0);
      check("R7", stretch_cnt, per_word & 1);
      stretch_cnt = 0;
      if (tag == "R5") tag = "R1";
    end
  endtask

  task automatic run_periods(input int n);
    int seen = 0;
    while (seen < n) begin
      tick();
      if (exp_pulse) seen++;
    end
  endtask

  task automatic apply_reset(input logic [STAGES-1:0] w);
    @(negedge clk_i);
    rst_ni = 1'b0;
    mod_i  = w;
    repeat (3) @(negedge clk_i);
    // R4
    check("R4", int'(div_o), 0);
    check("R4", int'(stage_o), 0);
    model_reset();
    rst_ni = 1'b1;
    tag    = "R5";
  endtask

  initial begin
    model_reset();
    apply_reset(4'd5);
    run_periods(2);

    // R1: every word, two periods each
    for (int w = 0; w < 16; w++) begin
      mod_i = 4'(w);
      run_periods(3);
    end

    // R2: word rewritten at drifting points inside periods
    tag = "R2";
    for (int k = 0; k < 90; k++) begin
      mod_i = 4'((k * 7 + 3) % 16);
      repeat (5 + (k % 4)) tick();
    end
    run_periods(2);

    // R3: extremes back to back
    tag = "R3";
    for (int k = 0; k < 6; k++) begin
      mod_i = (k % 2 == 0) ? 4'd0 : 4'd15;
      run_periods(1);
    end

    // R4/R5: reset mid-run with a new word
    repeat (7) tick();
    apply_reset(4'd11);
    run_periods(3);
    apply_reset(4'd0);
    run_periods(2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule